// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Packed Status Word

This block performs one integer arithmetic or bitwise operation per clock on two 16-bit operands, in either byte or word width, and returns the result together with a 16-bit status word. The status word holds the condition bits produced by the operation and three control bits. The control bits are copied from the incoming status word unless a flag command asks for one of them to change. A decode stage feeds the block an operation code, a width select, the current status word and an optional flag command. One cycle later the block returns the result, a write-back enable and the new status word.

Status bit positions are fixed: carry at bit 0, parity at bit 2, half-carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt-enable at bit 9, direction at bit 10 and overflow at bit 11. The block always drives every other bit to 0. In byte mode only the low eight operand bits are used, the result is zero-extended, and carry, sign and overflow refer to bit 7. In word mode they refer to bit 15.

Top module: `alu16_flags`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `wr_en_o` and `flags_o` become 0 at that edge.
- R2: The inputs present at a rising edge set all outputs from that edge on. The outputs do not change between edges.
- R3: Operation codes 0 (add) and 1 (add with carry) compute A+B, plus the incoming bit 0 for code 1. Carry is the carry out of the active width's top bit.
- R4: Codes 2 (subtract), 3 (subtract with borrow), 4 (compare) and 7 (negate) compute A-B, A-B-(incoming bit 0), A-B and 0-A respectively. Carry is set when a borrow occurs. For negate this means carry is set when the active-width A is nonzero.
- R5: Codes 5 (increment, A+1) and 6 (decrement, A-1) update every condition bit except carry, which keeps its incoming value.
- R6: After an arithmetic code, parity is set when the low result byte has an even number of ones. Zero is set when the active-width result is 0. Sign is the result's top active bit. Half-carry is the carry or borrow between bits 3 and 4. Overflow is set on a signed overflow of the active width.
- R7: Compare (4) and test (11) assert `wr_en_o` low. Every other code from 0 to 12 asserts it high. Compare sets the flags as subtract does, and test sets them as AND does.
- R8: Codes 8 (AND), 9 (OR), 10 (XOR) and 11 (test) form the bitwise result and clear carry, half-carry and overflow. Code 12 (NOT) returns the complement of A and leaves all defined status bits equal to the incoming ones.
- R9: With `wide_i` low (byte width), only bits 7:0 of the operands are used and `result_o[15:8]` is 0. With `wide_i` high, all 16 bits are used.
- R10: With `flag_cmd_i` = 0, trap, interrupt-enable and direction (bits 8, 9, 10) equal the incoming bits.
- R11: A nonzero `flag_cmd_i` replaces the operation: 1 sets carry, 2 clears carry, 3 inverts carry, 4 sets direction, 5 clears direction, 6 sets interrupt-enable, 7 clears interrupt-enable. All other defined status bits are copied, `result_o` is 0 and `wr_en_o` is low.
- R12: Status bits 1, 3, 5 and 12 to 15 are always 0 on `flags_o`, whatever `flags_in_i` holds.
- R13: Codes 13 to 15 give a result of 0, write-back low, and the defined incoming status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (see R3 to R8, R13) |
| wide_i | input | 1 | 1 = word width, 0 = byte width |
| opnd_a_i | input | 16 | First operand |
| opnd_b_i | input | 16 | Second operand |
| flags_in_i | input | 16 | Current status word |
| flag_cmd_i | input | 3 | Flag command, 0 = none (see R11) |
| result_o | output | 16 | Registered result |
| wr_en_o | output | 1 | Registered write-back enable |
| flags_o | output | 16 | Registered new status word |

## Verification
The assertions assume that the inputs are known and stable across each rising edge, since every property ties one cycle's inputs to the next cycle's outputs. They also assume reset has been released for at least one edge before a consequent is checked. The stimulus changes inputs only on falling edges and keeps every input at a defined value from time zero. For each operation code, both widths and both incoming carry values, it sweeps a byte grid, word corner values and pseudo-random words, with undefined status bits set to 1. The flag commands are applied on top of incoming status words with mixed control bits.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int FLAG_W = 16;

    localparam int CF_BIT = 0;
    localparam int PF_BIT = 2;
    localparam int AF_BIT = 4;
    localparam int ZF_BIT = 6;
    localparam int SF_BIT = 7;
    localparam int TF_BIT = 8;
    localparam int IF_BIT = 9;
    localparam int DF_BIT = 10;
    localparam int OF_BIT = 11;

    localparam logic [FLAG_W-1:0] FLAG_DEF_MASK =
        FLAG_W'((1 << CF_BIT) | (1 << PF_BIT) | (1 << AF_BIT) | (1 << ZF_BIT) |
                (1 << SF_BIT) | (1 << TF_BIT) | (1 << IF_BIT) | (1 << DF_BIT) |
                (1 << OF_BIT));

    typedef enum logic [3:0] {
        OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
        OP_CMP = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_NEG = 4'd7,
        OP_AND = 4'd8, OP_OR = 4'd9, OP_XOR = 4'd10, OP_TST = 4'd11,
        OP_NOT = 4'd12, OP_R13 = 4'd13, OP_R14 = 4'd14, OP_R15 = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        FC_NONE = 3'd0, FC_SET_C = 3'd1, FC_CLR_C = 3'd2, FC_INV_C = 3'd3,
        FC_SET_D = 3'd4, FC_CLR_D = 3'd5, FC_SET_I = 3'd6, FC_CLR_I = 3'd7
    } flag_cmd_e;

    typedef enum logic [1:0] {
        UPD_ARITH, UPD_KEEPC, UPD_LOGIC, UPD_HOLD
    } flag_upd_e;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic              cin;
        logic              sub;
    } addsub_req_t;

    typedef struct packed {
        logic [WORD_W-1:0] sum;
        logic              co;
        logic              ac;
        logic              ov;
    } addsub_rsp_t;

    function automatic logic [WORD_W-1:0] width_mask(input logic wide);
        return wide ? {WORD_W{1'b1}} : {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    endfunction

    function automatic logic even_ones(input logic [BYTE_W-1:0] v);
        return ~^v;
    endfunction
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
    import alu16_pkg::*;
(
    input  addsub_req_t req,
    input  logic        wide,
    output addsub_rsp_t rsp
);
    logic [WORD_W:0]   ext;
    logic [WORD_W-1:0] mask, a_m, b_m;
    logic              sa, sb, sr;

    always_comb begin
        mask = width_mask(wide);
        a_m  = req.a & mask;
        b_m  = req.b & mask;
        if (req.sub)
            ext = {1'b0, a_m} - {1'b0, b_m} - {{WORD_W{1'b0}}, req.cin};
        else
            ext = {1'b0, a_m} + {1'b0, b_m} + {{WORD_W{1'b0}}, req.cin};
        sa = wide ? a_m[WORD_W-1] : a_m[BYTE_W-1];
        sb = wide ? b_m[WORD_W-1] : b_m[BYTE_W-1];
        sr = wide ? ext[WORD_W-1] : ext[BYTE_W-1];
        rsp.sum = ext[WORD_W-1:0] & mask;
        rsp.co  = wide ? ext[WORD_W] : ext[BYTE_W];
        rsp.ac  = a_m[4] ^ b_m[4] ^ ext[4];
        rsp.ov  = req.sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
(
    input  alu_op_e           op,
    input  logic              wide,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] res
);
    logic [WORD_W-1:0] raw;

    always_comb begin
        unique case (op)
            OP_AND, OP_TST: raw = a & b;
            OP_OR:          raw = a | b;
            OP_XOR:         raw = a ^ b;
            OP_NOT:         raw = ~a;
            default:        raw = '0;
        endcase
        res = raw & width_mask(wide);
    end
endmodule

// File: rtl/alu16_flagpack.sv
module alu16_flagpack
    import alu16_pkg::*;
(
    input  logic [WORD_W-1:0] res,
    input  logic              wide,
    input  flag_upd_e         upd,
    input  addsub_rsp_t       ar,
    input  logic [FLAG_W-1:0] fin,
    input  flag_cmd_e         cmd,
    output logic [FLAG_W-1:0] fout
);
    logic zr, sg;

    always_comb begin
        fout = fin & FLAG_DEF_MASK;
        zr   = (res == '0);
        sg   = wide ? res[WORD_W-1] : res[BYTE_W-1];
        if (cmd != FC_NONE) begin
            unique case (cmd)
                FC_SET_C: fout[CF_BIT] = 1'b1;
                FC_CLR_C: fout[CF_BIT] = 1'b0;
                FC_INV_C: fout[CF_BIT] = ~fin[CF_BIT];
                FC_SET_D: fout[DF_BIT] = 1'b1;
                FC_CLR_D: fout[DF_BIT] = 1'b0;
                FC_SET_I: fout[IF_BIT] = 1'b1;
                FC_CLR_I: fout[IF_BIT] = 1'b0;
                default:  fout[CF_BIT] = fin[CF_BIT];
            endcase
        end else if (upd != UPD_HOLD) begin
            fout[PF_BIT] = even_ones(res[BYTE_W-1:0]);
            fout[ZF_BIT] = zr;
            fout[SF_BIT] = sg;
            if (upd == UPD_LOGIC) begin
                fout[CF_BIT] = 1'b0;
                fout[AF_BIT] = 1'b0;
                fout[OF_BIT] = 1'b0;
            end else begin
                fout[AF_BIT] = ar.ac;
                fout[OF_BIT] = ar.ov;
                if (upd == UPD_ARITH)
                    fout[CF_BIT] = ar.co;
            end
        end
    end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  op_i,
    input  logic        wide_i,
    input  logic [15:0] opnd_a_i,
    input  logic [15:0] opnd_b_i,
    input  logic [15:0] flags_in_i,
    input  logic [2:0]  flag_cmd_i,
    output logic [15:0] result_o,
    output logic        wr_en_o,
    output logic [15:0] flags_o
);
    alu_op_e           op;
    flag_cmd_e         cmd;
    addsub_req_t       req;
    addsub_rsp_t       rsp;
    flag_upd_e         upd;
    logic              use_arith, wb;
    logic [WORD_W-1:0] logic_res, res_nxt;
    logic [FLAG_W-1:0] flags_nxt;

    always_comb begin
        op        = alu_op_e'(op_i);
        cmd       = flag_cmd_e'(flag_cmd_i);
        req.a     = opnd_a_i;
        req.b     = opnd_b_i;
        req.cin   = 1'b0;
        req.sub   = 1'b0;
        use_arith = 1'b1;
        upd       = UPD_ARITH;
        wb        = 1'b1;
        unique case (op)
            OP_ADD: ;
            OP_ADC: req.cin = flags_in_i[CF_BIT];
            OP_SUB: req.sub = 1'b1;
            OP_SBB: begin req.sub = 1'b1; req.cin = flags_in_i[CF_BIT]; end
            OP_CMP: begin req.sub = 1'b1; wb = 1'b0; end
            OP_INC: begin req.b = WORD_W'(1); upd = UPD_KEEPC; end
            OP_DEC: begin req.b = WORD_W'(1); req.sub = 1'b1; upd = UPD_KEEPC; end
            OP_NEG: begin req.a = '0; req.b = opnd_a_i; req.sub = 1'b1; end
            OP_AND, OP_OR, OP_XOR: begin use_arith = 1'b0; upd = UPD_LOGIC; end
            OP_TST: begin use_arith = 1'b0; upd = UPD_LOGIC; wb = 1'b0; end
            OP_NOT: begin use_arith = 1'b0; upd = UPD_HOLD; end
            default: begin use_arith = 1'b0; upd = UPD_HOLD; wb = 1'b0; end
        endcase
        res_nxt = use_arith ? rsp.sum : logic_res;
        if (cmd != FC_NONE) begin
            wb      = 1'b0;
            res_nxt = '0;
        end
    end

    alu16_addsub u_addsub (.req(req), .wide(wide_i), .rsp(rsp));

    alu16_logic u_logic (
        .op(op), .wide(wide_i), .a(opnd_a_i), .b(opnd_b_i), .res(logic_res)
    );

    alu16_flagpack u_flagpack (
        .res(res_nxt), .wide(wide_i), .upd(upd), .ar(rsp),
        .fin(flags_in_i), .cmd(cmd), .fout(flags_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            wr_en_o  <= 1'b0;
            flags_o  <= '0;
        end else begin
            result_o <= res_nxt;
            wr_en_o  <= wb;
            flags_o  <= flags_nxt;
        end
    end
endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  op_i,
    input logic        wide_i,
    input logic [15:0] opnd_a_i,
    input logic [15:0] opnd_b_i,
    input logic [15:0] flags_in_i,
    input logic [2:0]  flag_cmd_i,
    input logic [15:0] result_o,
    input logic        wr_en_o,
    input logic [15:0] flags_o
);
    logic [15:0] act_mask;
    logic        no_cmd;
    assign act_mask = wide_i ? 16'hFFFF : 16'h00FF;
    assign no_cmd   = (flag_cmd_i == 3'd0);

    // R7
    cmp_test_nowb_chk: assert property (@(posedge clk) disable iff (rst)
        (no_cmd && (op_i == 4'd4 || op_i == 4'd11)) |=> !wr_en_o);

    // R5
    incdec_keepc_chk: assert property (@(posedge clk) disable iff (rst)
        (no_cmd && (op_i == 4'd5 || op_i == 4'd6)) |=> flags_o[0] == $past(flags_in_i[0]));

    // R10
    ctrl_pass_chk: assert property (@(posedge clk) disable iff (rst)
        no_cmd |=> flags_o[10:8] == $past(flags_in_i[10:8]));

    // R8
    logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (no_cmd && op_i >= 4'd8 && op_i <= 4'd11) |=> (!flags_o[0] && !flags_o[4] && !flags_o[11]));

    // R8
    and_value_chk: assert property (@(posedge clk) disable iff (rst)
        (no_cmd && op_i == 4'd8) |=> result_o == $past(opnd_a_i & opnd_b_i & act_mask));

    // R4
    neg_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (no_cmd && op_i == 4'd7) |=> flags_o[0] == $past((opnd_a_i & act_mask) != 16'h0));

    // R9
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !wide_i |=> result_o[15:8] == 8'h00);

    // R11
    cmd_nowb_chk: assert property (@(posedge clk) disable iff (rst)
        !no_cmd |=> (!wr_en_o && result_o == 16'h0));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (no_cmd && op_i <= 4'd11) |=> flags_o[6] == (result_o == 16'h0));

    // R12
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_o & 16'hF02A) == 16'h0);
endmodule

bind alu16_flags alu16_flags_chk chk_i (
    .clk(clk), .rst(rst), .op_i(op_i), .wide_i(wide_i),
    .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .flags_in_i(flags_in_i),
    .flag_cmd_i(flag_cmd_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flags_o(flags_o)
);

// File: tb/alu16_flags_tb_top.sv
module alu16_flags_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic [15:0] opnd_a_i = '0;
    logic [15:0] opnd_b_i = '0;
    logic [15:0] flags_in_i = '0;
    logic [2:0]  flag_cmd_i = '0;
    logic [15:0] result_o;
    logic        wr_en_o;
    logic [15:0] flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [32:0] last_exp = '0;

    always #10 clk = ~clk;

    alu16_flags dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .wide_i(wide_i),
        .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .flags_in_i(flags_in_i),
        .flag_cmd_i(flag_cmd_i), .result_o(result_o), .wr_en_o(wr_en_o),
        .flags_o(flags_o)
    );

    function automatic int sx(int v, int half);
        return (v >= half) ? v - 2 * half : v;
    endfunction

    // returns {wr, result, flags}
    function automatic logic [32:0] model(int op, logic [15:0] a, logic [15:0] b,
                                          logic w, logic [15:0] fin, int cmd);
        int msk  = w ? 32'hFFFF : 32'hFF;
        int half = w ? 32768 : 128;
        int am = int'(a) & msk;
        int bm = int'(b) & msk;
        int c  = int'(fin[0]);
        int x = 0, y = 0, full = 0, sfull = 0, r = 0, mode = 0;
        logic wr = 1'b1;
        logic [15:0] f = fin & 16'h0FD5;
        logic [15:0] rr;
        case (op)
            0: begin x = am; y = bm; full = x + y; sfull = sx(x, half) + sx(y, half); mode = 1; end
            1: begin x = am; y = bm; full = x + y + c; sfull = sx(x, half) + sx(y, half) + c; mode = 1; end
            2, 4: begin x = am; y = bm; full = x - y; sfull = sx(x, half) - sx(y, half); mode = 1; end
            3: begin x = am; y = bm; full = x - y - c; sfull = sx(x, half) - sx(y, half) - c; mode = 1; end
            5: begin x = am; y = 1; full = x + 1; sfull = sx(x, half) + 1; mode = 2; end
            6: begin x = am; y = 1; full = x - 1; sfull = sx(x, half) - 1; mode = 2; end
            7: begin x = 0; y = am; full = -am; sfull = -sx(am, half); mode = 1; end
            8, 11: begin r = am & bm; mode = 3; end
            9: begin r = am | bm; mode = 3; end
            10: begin r = am ^ bm; mode = 3; end
            12: begin r = (~am) & msk; mode = 0; end
            default: begin r = 0; mode = 0; wr = 1'b0; end
        endcase
        if (op == 4 || op == 11) wr = 1'b0;
        if (mode == 1 || mode == 2) r = full & msk;
        rr = 16'(r);
        if (mode != 0) begin
            f[2] = ~^rr[7:0];
            f[6] = (r == 0);
            f[7] = w ? rr[15] : rr[7];
        end
        if (mode == 1 || mode == 2) begin
            f[4]  = 1'(((x ^ y ^ r) >> 4) & 1);
            f[11] = (sfull < -half) || (sfull > half - 1);
            if (mode == 1) f[0] = (full < 0) || (full > msk);
        end
        if (mode == 3) begin f[0] = 1'b0; f[4] = 1'b0; f[11] = 1'b0; end
        if (cmd != 0) begin
            f = fin & 16'h0FD5;
            case (cmd)
                1: f[0] = 1'b1;
                2: f[0] = 1'b0;
                3: f[0] = ~fin[0];
                4: f[10] = 1'b1;
                5: f[10] = 1'b0;
                6: f[9] = 1'b1;
                default: f[9] = 1'b0;
            endcase
            rr = '0;
            wr = 1'b0;
        end
        return {wr, rr, f};
    endfunction

    task automatic compare(logic [32:0] exp, string tag);
        checks++;
        if ({wr_en_o, result_o, flags_o} !== exp) begin
            errors++;
            $display("FAIL %s: got wr=%0b res=%h flags=%h, expected wr=%0b res=%h flags=%h",
                     tag, wr_en_o, result_o, flags_o, exp[32], exp[31:16], exp[15:0]);
        end
    endtask

    task automatic apply(int op, logic [15:0] a, logic [15:0] b, logic w,
                         logic [15:0] fin, int cmd, string tag);
        logic [32:0] exp;
        @(negedge clk);
        op_i = 4'(op); opnd_a_i = a; opnd_b_i = b; wide_i = w;
        flags_in_i = fin; flag_cmd_i = 3'(cmd);
        exp = model(op, a, b, w, fin, cmd);
        @(posedge clk);
        #1;
        compare(exp, tag);
        last_exp = exp;
    endtask

    function automatic string op_tag(int op);
        case (op)
            0, 1: return "R3";
            2, 3, 7: return "R4";
            4, 11: return "R7";
            5, 6: return "R5";
            8, 9, 10, 12: return "R8";
            default: return "R13";
        endcase
    endfunction

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic [15:0] corners [7] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                     16'hFFFF, 16'h00FF, 16'h0F0F};
        logic [15:0] ra, rb;

        // R1: reset clears outputs even with active inputs
        @(negedge clk);
        rst = 1'b1; op_i = 4'd12; opnd_a_i = 16'h1234; flags_in_i = 16'hFFFF; wide_i = 1'b1;
        @(posedge clk); #1;
        compare(33'h0, "R1");
        @(negedge clk); rst = 1'b0;

        // R2: output holds until the next rising edge
        apply(0, 16'h0011, 16'h0022, 1'b1, 16'h0000, 0, "R2");
        @(negedge clk);
        op_i = 4'd2; opnd_a_i = 16'h0005; opnd_b_i = 16'h0009;
        #5;
        compare(last_exp, "R2");
        @(posedge clk); #1;
        compare(model(2, 16'h0005, 16'h0009, 1'b1, 16'h0000, 0), "R2");

        // R6 corners
        apply(0, 16'h007F, 16'h0001, 1'b0, 16'h0000, 0, "R6");
        apply(0, 16'h7FFF, 16'h0001, 1'b1, 16'h0000, 0, "R6");
        apply(2, 16'h8000, 16'h0001, 1'b1, 16'h0000, 0, "R6");
        apply(0, 16'h00FF, 16'h0001, 1'b0, 16'h0000, 0, "R6");
        apply(3, 16'h0000, 16'h0000, 1'b1, 16'h0001, 0, "R4");
        apply(1, 16'hFFFF, 16'h0000, 1'b1, 16'h0001, 0, "R3");
        apply(5, 16'hFFFF, 16'h0000, 1'b1, 16'h0000, 0, "R5");
        apply(6, 16'h0000, 16'h0000, 1'b0, 16'h0001, 0, "R5");
        apply(7, 16'h0080, 16'h0000, 1'b0, 16'h0000, 0, "R4");
        apply(7, 16'h0000, 16'h0000, 1'b1, 16'h0001, 0, "R4");
        apply(8, 16'hABCD, 16'hFFFF, 1'b0, 16'h0801, 0, "R9");
        apply(12, 16'h1234, 16'h0000, 1'b1, 16'h0FD5, 0, "R8");
        apply(4, 16'h0003, 16'h0005, 1'b1, 16'h0000, 0, "R7");
        apply(11, 16'h00F0, 16'h000F, 1'b0, 16'h0000, 0, "R7");

        // R10 and R12: control bits pass, undefined bits dropped
        apply(0, 16'h0001, 16'h0001, 1'b1, 16'hF72A, 0, "R10");
        apply(9, 16'h0000, 16'h0000, 1'b1, 16'hFFFF, 0, "R12");

        // R11: every flag command over two incoming words
        for (int c = 1; c < 8; c++) begin
            apply(0, 16'h1111, 16'h2222, 1'b1, 16'hF0FF, c, "R11");
            apply(2, 16'h0001, 16'h0003, 1'b0, 16'h0700, c, "R11");
        end

        // R13: reserved codes
        for (int o = 13; o < 16; o++)
            apply(o, 16'h5A5A, 16'hA5A5, 1'b1, 16'hFFFF, 0, "R13");

        // R9: byte-width grid over all codes with upper operand bytes set
        for (int o = 0; o < 13; o++)
            for (int ai = 0; ai < 256; ai += 5)
                for (int bi = 0; bi < 256; bi += 17)
                    for (int c = 0; c < 2; c++)
                        apply(o, 16'(16'hC300 | ai), 16'(16'h3C00 | bi), 1'b0,
                              16'(16'hF02A | c | ((ai & 7) << 8)), 0,
                              (o == 0) ? "R9" : op_tag(o));

        // word corners
        for (int o = 0; o < 13; o++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    for (int c = 0; c < 2; c++)
                        apply(o, corners[i], corners[j], 1'b1, 16'(16'h0500 | c), 0, op_tag(o));

        // pseudo-random words
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ra = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rb = lfsr;
            apply(k % 13, ra, rb, 1'b1, {ra[15:12], rb[11:0]}, 0, op_tag(k % 13));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule